// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Spurious-Acknowledge Detection

This block sits between a set of device request lines and the single interrupt input of a processor. Each device line is sampled as a level. Any line that is unmasked and allowed by the in-service state makes the controller raise its processor request. The processor answers with a one-cycle acknowledge pulse. In the next cycle the controller returns an 8-bit vector, which is a programmable 5-bit base followed by the 3-bit number of the winning line. In manual mode the winner is recorded as in service. An explicit end-of-interrupt pulse from the processor then retires the highest-priority in-service line.

The processor may leave its request unanswered for any length of time, for example while its own interrupts are held off. During that time the controller keeps the request raised. A device can drop its line in that window. If no eligible line remains when the acknowledge arrives, the controller answers with the lowest-priority vector and a one-cycle spurious flag, and leaves the in-service state untouched. A mode bit selects automatic retirement. In that mode nothing is marked in service at acknowledge, so the next request can be raised at once.

Top module: `irq_hub`

## Requirements
- R1: Out of reset, `cpuIrq`, `vecValid` and `spurious` are low, the mask is clear, the base is zero, manual mode is selected and nothing is in service.
- R2: One cycle after an eligible line goes high, `cpuIrq` is high. A line is eligible when its `devReq` bit is 1, its mask bit is 0, and no line of equal or higher priority is in service.
- R3: Once `cpuIrq` is high, it stays high until an acknowledge is taken, even if every device line drops.
- R4: An acknowledge taken while `cpuIrq` is high produces, in the next cycle, a one-cycle `vecValid` pulse with `vecOut = {base, line}` for the winning line. `cpuIrq` is low in that cycle.
- R5: Priority is fixed and line 0 is the highest. The winner is the lowest-numbered line that is eligible in the acknowledge cycle.
- R6: In manual mode, the acknowledged line becomes in service. That line and lower-priority lines are not signalled until an end-of-interrupt. A line still high after the end-of-interrupt is signalled and delivered again. A higher-priority line can still be signalled while a lower one is in service.
- R7: A `cpuEoi` pulse clears only the highest-priority (lowest-numbered) in-service line.
- R8: With `cfgAutoEoi = 1`, an acknowledge marks nothing in service, so a line that is still high is signalled again right after the acknowledge.
- R9: An acknowledge with no eligible line produces a one-cycle `spurious` pulse with `vecOut = {base, 3'b111}`. `vecValid` stays low and the in-service state is unchanged.
- R10: The cycle after an acknowledge cycle, `cpuIrq` is high again if an eligible line remains, and low otherwise.
- R11: Mask bit i = 1 blocks line i from being signalled or selected. `cfgWr` loads the mask, base and mode together.
- R12: A `cpuAck` pulse while `cpuIrq` is low is ignored. It produces no vector, no spurious pulse and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| devReq | input | 8 | Level-sensitive device request lines, bit i is line i |
| cfgWr | input | 1 | Load strobe for mask, base and mode |
| cfgMask | input | 8 | New mask, bit i = 1 blocks line i |
| cfgBase | input | 5 | New vector base |
| cfgAutoEoi | input | 1 | New mode: 1 selects automatic retirement at acknowledge |
| cpuIrq | output | 1 | Interrupt request to the processor |
| cpuAck | input | 1 | One-cycle acknowledge from the processor |
| cpuEoi | input | 1 | One-cycle end-of-interrupt command |
| vecValid | output | 1 | One-cycle pulse: `vecOut` carries a real vector |
| vecOut | output | 8 | Returned vector {base, line} |
| spurious | output | 1 | One-cycle pulse: the acknowledge found no eligible line |

## Verification
The bench builds the block with its defaults: eight lines and a 5-bit base, which gives 8-bit vectors. At this size every line number can be reached, including line 7, whose vector is the same as the spurious one. Nesting up to two in-service levels can be set up while a lower-priority request is held pending. The scenarios check the interactions that matter: a request withdrawn while the processor is slow to acknowledge, a masked line beside an unmasked one, back-to-back delivery in automatic mode, and stray acknowledges.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  // Strobes the handshake control hands to the datapath for one cycle.
  typedef struct packed {
    logic grant;  // acknowledge taken with an eligible winner
    logic spur;   // acknowledge taken with nothing eligible
    logic eoi;    // retire highest-priority in-service line
  } hubStrobe_t;

endpackage

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int BASE_W    = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_LINES-1:0]                  devReq,
  input  logic                                  cfgWr,
  input  logic [NUM_LINES-1:0]                  cfgMask,
  input  logic [BASE_W-1:0]                     cfgBase,
  input  logic                                  cfgAutoEoi,
  input  hubStrobe_t                            strobe,
  output logic                                  anyEligible,
  output logic                                  vecValid,
  output logic [BASE_W+$clog2(NUM_LINES)-1:0]   vecOut,
  output logic                                  spurious
);

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int VEC_W = BASE_W + IDX_W;
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] maskQ;
  logic [BASE_W-1:0]    baseQ;
  logic                 autoEoiQ;
  logic [NUM_LINES-1:0] isrQ;

  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] blockedBy;   // in service at this line or above
  logic [NUM_LINES-1:0] eligible;
  logic [IDX_W-1:0]     winIdx;
  logic [NUM_LINES-1:0] ackSet;
  logic [NUM_LINES-1:0] eoiClr;
  logic [NUM_LINES-1:0] isrNext;

  assign pending = devReq & ~maskQ;

  // Prefix OR over the in-service bits, from line 0 downward in priority.
  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : gPrefix
      if (g == 0) begin : gFirst
        assign blockedBy[g] = isrQ[g];
      end else begin : gRest
        assign blockedBy[g] = blockedBy[g-1] | isrQ[g];
      end
      assign eligible[g] = pending[g] & ~blockedBy[g];
    end
  endgenerate

  assign anyEligible = |eligible;

  // Lowest-numbered eligible line wins.
  always_comb begin
    winIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eligible[i]) winIdx = IDX_W'(i);
    end
  end

  always_comb begin
    ackSet = '0;
    if (strobe.grant && !autoEoiQ) ackSet[winIdx] = 1'b1;
  end

  // Isolate the lowest set in-service bit: the highest-priority one.
  assign eoiClr  = strobe.eoi ? (isrQ & (~isrQ + NUM_LINES'(1))) : '0;
  assign isrNext = (isrQ & ~eoiClr) | ackSet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskQ    <= '0;
      baseQ    <= '0;
      autoEoiQ <= 1'b0;
    end else if (cfgWr) begin
      maskQ    <= cfgMask;
      baseQ    <= cfgBase;
      autoEoiQ <= cfgAutoEoi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isrQ     <= '0;
      vecValid <= 1'b0;
      spurious <= 1'b0;
      vecOut   <= '0;
    end else begin
      isrQ     <= isrNext;
      vecValid <= strobe.grant;
      spurious <= strobe.spur;
      if (strobe.grant) begin
        vecOut <= {baseQ, winIdx};
      end else if (strobe.spur) begin
        vecOut <= {baseQ, SPUR_IDX};
      end
    end
  end

  // ---------------- assertions ----------------
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(vecValid && spurious));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |=> !vecValid);

  assert_spur_keeps_isr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.spur && !strobe.eoi) |=> (isrQ == $past(isrQ)));

  assert_auto_no_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.grant && autoEoiQ && !strobe.eoi) |=> (isrQ == $past(isrQ)));

  assert_grant_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && !$past(autoEoiQ)) |-> isrQ[vecOut[IDX_W-1:0]]);

  assert_eoi_one_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.eoi && !strobe.grant && (isrQ != '0)) |=>
      ($countones(isrQ) == $countones($past(isrQ)) - 1));

  assert_masked_never_won_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && !$past(cfgWr)) |-> !maskQ[vecOut[IDX_W-1:0]]);

  logic unusedVecW;
  assign unusedVecW = (VEC_W == 0);

endmodule

// File: rtl/irq_hub_ctl.sv
module irq_hub_ctl
  import irq_hub_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpuAck,
  input  logic       cpuEoi,
  input  logic       anyEligible,
  output logic       cpuIrq,
  output hubStrobe_t strobe
);

  logic irqQ;
  logic ackLive;

  // An acknowledge only counts while the request is up.
  assign ackLive = cpuAck && irqQ;

  always_comb begin
    strobe.grant = ackLive && anyEligible;
    strobe.spur  = ackLive && !anyEligible;
    strobe.eoi   = cpuEoi;
  end

  // Raised on any eligible line, held until an acknowledge is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqQ <= 1'b0;
    end else if (ackLive) begin
      irqQ <= 1'b0;
    end else if (anyEligible) begin
      irqQ <= 1'b1;
    end
  end

  assign cpuIrq = irqQ;

  // ---------------- assertions ----------------
  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irqQ && !cpuAck) |=> irqQ);

  assert_irq_drops_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irqQ && cpuAck) |=> !irqQ);

  assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqQ && !anyEligible) |=> !irqQ);

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int BASE_W    = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_LINES-1:0]                 devReq,
  input  logic                                 cfgWr,
  input  logic [NUM_LINES-1:0]                 cfgMask,
  input  logic [BASE_W-1:0]                    cfgBase,
  input  logic                                 cfgAutoEoi,
  output logic                                 cpuIrq,
  input  logic                                 cpuAck,
  input  logic                                 cpuEoi,
  output logic                                 vecValid,
  output logic [BASE_W+$clog2(NUM_LINES)-1:0]  vecOut,
  output logic                                 spurious
);

  hubStrobe_t strobe;
  logic       anyEligible;

  irq_hub_ctl ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpuAck      (cpuAck),
    .cpuEoi      (cpuEoi),
    .anyEligible (anyEligible),
    .cpuIrq      (cpuIrq),
    .strobe      (strobe)
  );

  irq_hub_dp #(
    .NUM_LINES (NUM_LINES),
    .BASE_W    (BASE_W)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .devReq      (devReq),
    .cfgWr       (cfgWr),
    .cfgMask     (cfgMask),
    .cfgBase     (cfgBase),
    .cfgAutoEoi  (cfgAutoEoi),
    .strobe      (strobe),
    .anyEligible (anyEligible),
    .vecValid    (vecValid),
    .vecOut      (vecOut),
    .spurious    (spurious)
  );

endmodule

// File: tb/irq_hub_tb_top.sv
module irq_hub_tb_top;

  localparam logic [4:0] BASE = 5'h13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] devReq = '0;
  logic       cfgWr = 1'b0;
  logic [7:0] cfgMask = '0;
  logic [4:0] cfgBase = '0;
  logic       cfgAutoEoi = 1'b0;
  logic       cpuIrq;
  logic       cpuAck = 1'b0;
  logic       cpuEoi = 1'b0;
  logic       vecValid;
  logic [7:0] vecOut;
  logic       spurious;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_hub dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .devReq     (devReq),
    .cfgWr      (cfgWr),
    .cfgMask    (cfgMask),
    .cfgBase    (cfgBase),
    .cfgAutoEoi (cfgAutoEoi),
    .cpuIrq     (cpuIrq),
    .cpuAck     (cpuAck),
    .cpuEoi     (cpuEoi),
    .vecValid   (vecValid),
    .vecOut     (vecOut),
    .spurious   (spurious)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input logic [7:0] m, input logic [4:0] b, input logic a);
    cfgMask = m; cfgBase = b; cfgAutoEoi = a; cfgWr = 1'b1;
    tick(1);
    cfgWr = 1'b0;
  endtask

  // Acknowledge pulse; returns after the edge that took it.
  task automatic ack();
    cpuAck = 1'b1;
    tick(1);
    cpuAck = 1'b0;
  endtask

  task automatic eoi();
    cpuEoi = 1'b1;
    tick(1);
    cpuEoi = 1'b0;
  endtask

  task automatic expectVec(input string tag, input int line);
    chk({tag, " vecValid"}, vecValid, 1);
    chk({tag, " vecOut"}, vecOut, {BASE, 3'(line)});
    chk({tag, " spurious"}, spurious, 0);
  endtask

  task automatic testReset();
    chk("R1 cpuIrq", cpuIrq, 0);
    chk("R1 vecValid", vecValid, 0);
    chk("R1 spurious", spurious, 0);
  endtask

  task automatic testBasic();
    configure(8'h00, BASE, 1'b0);
    devReq = 8'h08;
    tick(1);
    chk("R2 raise", cpuIrq, 1);
    ack();
    expectVec("R4 line3", 3);
    chk("R4 irq low at vector", cpuIrq, 0);
    devReq = 8'h00;
    tick(1);
    chk("R4 single pulse", vecValid, 0);
    chk("R10 irq stays low", cpuIrq, 0);
    eoi();
  endtask

  task automatic testPriority();
    devReq = 8'hA4;  // lines 2, 5, 7
    tick(1);
    ack();
    expectVec("R5 lowest wins", 2);
    tick(2);
    chk("R6 blocked while in service", cpuIrq, 0);
    eoi();
    tick(1);
    chk("R6 re-raised after eoi", cpuIrq, 1);
    ack();
    expectVec("R6 pending delivered", 2);
    eoi();
    devReq = 8'hA0;
    tick(1);
    ack();
    expectVec("R5 next line", 5);
    eoi();
    devReq = 8'h80;
    tick(1);
    ack();
    expectVec("R5 line7", 7);
    devReq = 8'h00;
    eoi();
  endtask

  task automatic testNest();
    devReq = 8'h08;
    tick(1);
    ack();
    expectVec("R6 outer", 3);
    devReq = 8'h20;
    tick(2);
    chk("R6 lower blocked", cpuIrq, 0);
    devReq = 8'h22;
    tick(1);
    chk("R6 higher nests", cpuIrq, 1);
    ack();
    expectVec("R6 inner", 1);
    devReq = 8'h20;
    eoi();
    tick(2);
    chk("R7 only top bit cleared", cpuIrq, 0);
    eoi();
    tick(1);
    chk("R7 second eoi frees", cpuIrq, 1);
    ack();
    expectVec("R7 line5", 5);
    devReq = 8'h00;
    eoi();
  endtask

  task automatic testAuto();
    configure(8'h00, BASE, 1'b1);
    devReq = 8'h10;
    tick(1);
    ack();
    expectVec("R8 first", 4);
    tick(1);
    chk("R8 re-raise no isr", cpuIrq, 1);
    ack();
    expectVec("R8 second", 4);
    devReq = 8'h00;
    tick(1);
    chk("R10 low when idle", cpuIrq, 0);
    configure(8'h00, BASE, 1'b0);
  endtask

  task automatic testSpurious();
    devReq = 8'h10;
    tick(1);
    chk("R2 raise line4", cpuIrq, 1);
    devReq = 8'h00;
    tick(3);
    chk("R3 held after withdraw", cpuIrq, 1);
    ack();
    chk("R9 spurious", spurious, 1);
    chk("R9 no vecValid", vecValid, 0);
    chk("R9 vector", vecOut, {BASE, 3'd7});
    tick(1);
    chk("R9 pulse ends", spurious, 0);
    chk("R10 low after spurious", cpuIrq, 0);
    devReq = 8'h40;
    tick(1);
    chk("R9 isr unchanged", cpuIrq, 1);
    ack();
    expectVec("R9 line6", 6);
    devReq = 8'h00;
    eoi();
    // Spurious with another line arriving just after.
    devReq = 8'h04;
    tick(1);
    devReq = 8'h00;
    tick(1);
    ack();
    chk("R9 second spurious", spurious, 1);
    devReq = 8'h01;
    tick(2);
    chk("R10 new line raises", cpuIrq, 1);
    ack();
    expectVec("R9 line0 after", 0);
    devReq = 8'h00;
    eoi();
  endtask

  task automatic testMask();
    configure(8'h08, BASE, 1'b0);
    devReq = 8'h08;
    tick(2);
    chk("R11 masked silent", cpuIrq, 0);
    devReq = 8'h48;
    tick(1);
    chk("R11 unmasked raises", cpuIrq, 1);
    ack();
    expectVec("R11 masked skipped", 6);
    eoi();
    devReq = 8'h08;
    configure(8'h00, BASE, 1'b0);
    tick(1);
    chk("R11 unmask raises", cpuIrq, 1);
    ack();
    expectVec("R11 line3", 3);
    devReq = 8'h00;
    eoi();
  endtask

  task automatic testStray();
    tick(1);
    ack();
    chk("R12 no vector", vecValid, 0);
    chk("R12 no spurious", spurious, 0);
    devReq = 8'h01;
    tick(1);
    chk("R12 irq normal", cpuIrq, 1);
    ack();
    expectVec("R12 state intact", 0);
    devReq = 8'h00;
    eoi();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    testReset();
    testBasic();
    testPriority();
    testNest();
    testAuto();
    testSpurious();
    testMask();
    testStray();
    tick(2);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finishRun();
  end

endmodule